// File: doc/BRIEF.md
# Event Notification Trigger Generator

This block turns interrupt-source events into memory-store notifications. Up to twenty level-sensitive sources feed a level register in which source n occupies bit 63−n, the most-significant-bit-first numbering. A separate request port names a source whose event is to be announced. Each announcement becomes one 64-bit store to a programmable target address. The store data combines a trigger flag constant, a table offset and the source number.

Announcements are queued in a small in-order queue, and at most one store is in flight at any time. A store is only issued while the valid flag of the target-address register is set. If the flag is clear, the queued announcement is consumed and dropped. An error response on the store channel sets a sticky error flag.

Software reaches three writable registers and one read-only register through a simple word-wide register port. The control register carries two bits with a meaning. One selects a level-signalled delivery method that the block does not support. The other requests a reset of the downstream event-source state, which the block signals as a one-cycle pulse.

Top module: `evt_trigger_gen`

## Requirements
- R1: After reset, all four registers read zero, no store is requested, `ntf_ready` is high, and `st_err`, `method_err` and `src_reset` are low.
- R2: While control bit 63 is clear, register 3 (the level register) shows `src_lvl[n]` at bit 63−n one cycle after the input is sampled. Bits below 64−NSRC read zero.
- R3: While control bit 63 is set, the level register holds its value. Any difference between the inputs and the held value sets the sticky flag `method_err`.
- R4: A write to register 0 (control) stores the full written value. If bit 62 of the written value is set, `src_reset` is high for exactly the following cycle.
- R5: A queued announcement popped while register 1 (address) bit 63 is set issues one store. Its address is register 1 with bit 63 cleared. Its data is TRIG_FLAG OR {32'b0, register 2 bits [63:32]} OR the source number. Address and data stay stable while `st_valid` waits for `st_ready`.
- R6: A queued announcement popped while register 1 bit 63 is clear is consumed with no store issued.
- R7: Announcements are served in arrival order, with at most one store outstanding between request acceptance and response. `ntf_ready` is low when QDEPTH announcements are waiting, and a request offered then is lost.
- R8: A store response with `st_rsp_err` high sets the sticky flag `st_err`.
- R9: Register addresses 4 to 7 read all ones. Writes to them, and to the read-only level register, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | NSRC | Source level inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register word address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| ntf_valid | input | 1 | Announcement request |
| ntf_src | input | SRC_W | Source number of the announcement |
| ntf_ready | output | 1 | Queue can accept an announcement |
| st_valid | output | 1 | Store request valid |
| st_addr | output | 64 | Store byte address |
| st_data | output | 64 | Store data, most significant byte in lane [63:56] |
| st_ready | input | 1 | Store request accepted |
| st_rsp_valid | input | 1 | Store response |
| st_rsp_err | input | 1 | Store response is an error |
| st_err | output | 1 | Sticky store-error flag |
| method_err | output | 1 | Sticky unsupported-method flag |
| src_reset | output | 1 | One-cycle event-source reset pulse |

## Verification
A corrupted queue pointer or count shows up in one of three ways: a store for the wrong source, a store out of order, or `ntf_ready` at the wrong level. The store shows the error on the first store after the fault, and `ntf_ready` shows it in the same cycle. A wrong engine state shows as a second `st_valid` before a response, or a store that never ends, and it becomes visible within a cycle or two of the next announcement. Stale or wrongly captured register values appear directly in `st_addr` or `st_data`, in the cycle `st_valid` rises. The level and control registers are exposed through `reg_rdata` and are compared against a reference model every cycle.

// File: rtl/evt_trigger_gen.sv
module evt_trigger_gen #(
  parameter int          NSRC      = 20,
  parameter int          QDEPTH    = 4,
  parameter int          RA_W      = 3,
  parameter logic [63:0] TRIG_FLAG = 64'h0000_0000_8000_0000,
  localparam int         SRC_W     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_lvl,
  input  logic             reg_we,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [63:0]      reg_wdata,
  output logic [63:0]      reg_rdata,
  input  logic             ntf_valid,
  input  logic [SRC_W-1:0] ntf_src,
  output logic             ntf_ready,
  output logic             st_valid,
  output logic [63:0]      st_addr,
  output logic [63:0]      st_data,
  input  logic             st_ready,
  input  logic             st_rsp_valid,
  input  logic             st_rsp_err,
  output logic             st_err,
  output logic             method_err,
  output logic             src_reset
);
  localparam int QP_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP} eng_t;

  logic [63:0] ctl_q, adr_q, ofs_q, lvl_q, lvl_in;
  logic        serr_q, merr_q, srst_q;
  eng_t        eng_q;
  logic [63:0] sa_q, sd_q;

  logic [SRC_W-1:0] q_mem [QDEPTH];
  logic [QP_W-1:0]  wp_q, rp_q;
  logic [QP_W:0]    cnt_q;
  logic             push, pop;

  wire wr_ctl = reg_we && reg_addr == RA_W'(0);
  wire wr_adr = reg_we && reg_addr == RA_W'(1);
  wire wr_ofs = reg_we && reg_addr == RA_W'(2);

  always_comb begin
    lvl_in = '0;
    for (int n = 0; n < NSRC; n++) lvl_in[63-n] = src_lvl[n];
  end

  always_comb begin
    case (reg_addr)
      RA_W'(0): reg_rdata = ctl_q;
      RA_W'(1): reg_rdata = adr_q;
      RA_W'(2): reg_rdata = ofs_q;
      RA_W'(3): reg_rdata = lvl_q;
      default:  reg_rdata = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      adr_q  <= '0;
      ofs_q  <= '0;
      lvl_q  <= '0;
      merr_q <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      if (wr_ctl) ctl_q <= reg_wdata;
      if (wr_adr) adr_q <= reg_wdata;
      if (wr_ofs) ofs_q <= reg_wdata;
      srst_q <= wr_ctl && reg_wdata[62];
      if (!ctl_q[63])         lvl_q  <= lvl_in;
      else if (lvl_in != lvl_q) merr_q <= 1'b1;
    end
  end

  assign ntf_ready = cnt_q != (QP_W+1)'(QDEPTH);
  assign push      = ntf_valid && ntf_ready;
  assign pop       = eng_q == S_IDLE && cnt_q != '0;

  always_ff @(posedge clk) begin
    if (push) q_mem[wp_q] <= ntf_src;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= (wp_q == QP_W'(QDEPTH-1)) ? '0 : wp_q + 1'b1;
      if (pop)  rp_q <= (rp_q == QP_W'(QDEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + (QP_W+1)'(push) - (QP_W+1)'(pop);
    end
  end

  wire [63:0] trig = TRIG_FLAG | {32'b0, ofs_q[63:32]} | 64'(q_mem[rp_q]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eng_q  <= S_IDLE;
      sa_q   <= '0;
      sd_q   <= '0;
      serr_q <= 1'b0;
    end else begin
      case (eng_q)
        S_IDLE: if (pop && adr_q[63]) begin
          sa_q  <= {1'b0, adr_q[62:0]};
          sd_q  <= trig;
          eng_q <= S_REQ;
        end
        S_REQ: if (st_ready) eng_q <= S_RSP;
        S_RSP: if (st_rsp_valid) begin
          if (st_rsp_err) serr_q <= 1'b1;
          eng_q <= S_IDLE;
        end
        default: eng_q <= S_IDLE;
      endcase
    end
  end

  assign st_valid   = eng_q == S_REQ;
  assign st_addr    = sa_q;
  assign st_data    = sd_q;
  assign st_err     = serr_q;
  assign method_err = merr_q;
  assign src_reset  = srst_q;
endmodule

// File: rtl/evt_trigger_gen_chk.sv
module evt_trigger_gen_chk #(
  parameter logic [63:0] TRIG_FLAG = 64'h0000_0000_8000_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_rst_wr,
  input logic        st_valid,
  input logic        st_ready,
  input logic        st_addr_top,
  input logic [63:0] st_data,
  input logic        st_rsp_valid,
  input logic        st_rsp_err,
  input logic        st_err,
  input logic        method_err,
  input logic        src_reset
);
  logic out_q;
  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= 1'b0;
    else if (st_valid && st_ready) out_q <= 1'b1;
    else if (st_rsp_valid) out_q <= 1'b0;
  end

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n) st_valid |-> !out_q); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) st_valid && !st_ready |=> st_valid && $stable(st_data)); // R5
  AST_ADDR_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) st_valid |-> !st_addr_top); // R5
  AST_TRIG_FLAG: assert property (@(posedge clk) disable iff (!rst_n) st_valid |-> (st_data & TRIG_FLAG) == TRIG_FLAG); // R5
  AST_STORE_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) st_err |=> st_err); // R8
  AST_STORE_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(st_err) |-> $past(st_rsp_valid && st_rsp_err)); // R8
  AST_METHOD_STICKY: assert property (@(posedge clk) disable iff (!rst_n) method_err |=> method_err); // R3
  AST_RESET_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) src_reset |-> $past(ctl_rst_wr)); // R4
endmodule

bind evt_trigger_gen evt_trigger_gen_chk #(.TRIG_FLAG(TRIG_FLAG)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .ctl_rst_wr(reg_we && reg_addr == '0 && reg_wdata[62]),
  .st_valid(st_valid),
  .st_ready(st_ready),
  .st_addr_top(st_addr[63]),
  .st_data(st_data),
  .st_rsp_valid(st_rsp_valid),
  .st_rsp_err(st_rsp_err),
  .st_err(st_err),
  .method_err(method_err),
  .src_reset(src_reset)
);

// File: tb/tb_evt_trigger_gen.sv
module tb_evt_trigger_gen;
  localparam int          NSRC = 20;
  localparam int          QD   = 4;
  localparam logic [63:0] TRIG = 64'h0000_0000_8000_0000;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] src_lvl = '0;
  logic reg_we = 0;
  logic [2:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic ntf_valid = 0;
  logic [4:0] ntf_src = '0;
  logic ntf_ready, st_valid, st_ready = 1, st_rsp_valid, st_rsp_err;
  logic [63:0] st_addr, st_data;
  logic st_err, method_err, src_reset;
  logic err_mode = 0;
  logic [1:0] rcnt;

  int total = 0, bad = 0;
  bit cmp_on = 0;

  always #5 clk = ~clk;

  evt_trigger_gen dut (.*);

  always @(posedge clk) begin
    if (!rst_n) rcnt <= 0;
    else if (st_valid && st_ready) rcnt <= 2;
    else if (rcnt != 0) rcnt <= rcnt - 1;
  end
  assign st_rsp_valid = rcnt == 1;
  assign st_rsp_err   = err_mode;

  logic [63:0] m_ctl, m_adr, m_ofs, m_lvl, m_addr, m_data, li, oc, oa, oo;
  bit m_serr, m_merr, m_rst, pu;
  int m_ph, s;
  int q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = 0; m_adr = 0; m_ofs = 0; m_lvl = 0; m_serr = 0; m_merr = 0;
      m_rst = 0; m_ph = 0; q.delete();
    end else begin
      li = 0;
      for (int n = 0; n < NSRC; n++) li[63-n] = src_lvl[n];
      pu = ntf_valid && q.size() < QD;
      oc = m_ctl; oa = m_adr; oo = m_ofs;
      case (m_ph)
        0: if (q.size() > 0) begin
             s = q.pop_front();
             if (oa[63]) begin
               m_addr = oa & ~(64'h1 << 63);
               m_data = TRIG | {32'h0, oo[63:32]} | 64'(s);
               m_ph = 1;
             end
           end
        1: if (st_ready) m_ph = 2;
        default: if (st_rsp_valid) begin
             if (st_rsp_err) m_serr = 1;
             m_ph = 0;
           end
      endcase
      if (reg_we && reg_addr == 0) m_ctl = reg_wdata;
      if (reg_we && reg_addr == 1) m_adr = reg_wdata;
      if (reg_we && reg_addr == 2) m_ofs = reg_wdata;
      m_rst = reg_we && reg_addr == 0 && reg_wdata[62];
      if (!oc[63]) m_lvl = li;
      else if (li != m_lvl) m_merr = 1;
      if (pu) q.push_back(int'(ntf_src));
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] m_rd(logic [2:0] a);
    case (a)
      0: return m_ctl;
      1: return m_adr;
      2: return m_ofs;
      3: return m_lvl;
      default: return '1;
    endcase
  endfunction

  always @(negedge clk) if (cmp_on) begin
    if (!rst_n) begin
      chk("R1 st_valid", 64'(st_valid), 0);
      chk("R1 st_err", 64'(st_err), 0);
    end else begin
      chk(reg_addr == 3 ? "R2/R3 level read" : reg_addr == 0 ? "R4 control read" :
          reg_addr > 3 ? "R9 unmapped read" : "R5 address/offset read",
          reg_rdata, m_rd(reg_addr));
      chk("R6 st_valid", 64'(st_valid), 64'(m_ph == 1));
      if (st_valid && m_ph == 1) begin
        chk("R5 st_addr", st_addr, m_addr);
        chk("R5 st_data", st_data, m_data);
      end
      chk("R7 ntf_ready", 64'(ntf_ready), 64'(q.size() < QD));
      chk("R8 st_err", 64'(st_err), 64'(m_serr));
      chk("R3 method_err", 64'(method_err), 64'(m_merr));
      chk("R4 src_reset", 64'(src_reset), 64'(m_rst));
    end
  end

  task automatic cyc(); @(negedge clk); #1; endtask
  task automatic idle(int n); repeat (n) cyc(); endtask
  task automatic wreg(logic [2:0] a, logic [63:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d; cyc(); reg_we = 0;
  endtask
  task automatic notify(int sn);
    ntf_valid = 1; ntf_src = 5'(sn); cyc(); ntf_valid = 0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cmp_on = 1;
    idle(3);
    for (int a = 0; a < 8; a++) begin reg_addr = 3'(a); cyc(); end // R1 reset values
    rst_n = 1;
    reg_addr = 3;
    src_lvl = 20'h80001; idle(2);                       // R2
    src_lvl = 20'h0F0F0; idle(2);                       // R2
    notify(4); idle(4);                                 // R6 address not valid
    wreg(1, 64'h8000_0000_0000_1000);
    wreg(2, 64'h0000_0055_0000_0000);
    notify(3); idle(6);                                 // R5
    st_ready = 0;
    for (int i = 0; i < 7; i++) notify(10 + i);         // R7 queue fill
    idle(3); st_ready = 1; idle(30);
    err_mode = 1; notify(19); idle(6); err_mode = 0;    // R8
    reg_addr = 0;
    wreg(0, 64'h4000_0000_0000_00AA); idle(2);          // R4
    reg_addr = 3;
    wreg(0, 64'h8000_0000_0000_0000);                   // R3
    src_lvl = 20'h00F00; idle(3);
    wreg(0, 64'h0); idle(2);
    wreg(5, 64'h1234); reg_addr = 5; idle(1);           // R9
    wreg(3, 64'h0); reg_addr = 3; idle(2);              // R9
    wreg(1, 64'h0000_0000_0000_2000); notify(7); idle(4); // R6
    for (int i = 0; i < 600; i++) begin
      src_lvl   = ($urandom % 8 == 0) ? NSRC'($urandom) : src_lvl;
      st_ready  = ($urandom % 3) != 0;
      err_mode  = ($urandom % 5) == 0;
      ntf_valid = ($urandom % 3) == 0;
      ntf_src   = 5'($urandom % NSRC);
      reg_we    = ($urandom % 10) == 0;
      reg_wdata = {$urandom, $urandom};
      reg_addr  = 3'($urandom);
      if (reg_we && reg_addr == 0) reg_wdata[63] = ($urandom % 4) == 0;
      if (reg_we && reg_addr == 1) reg_wdata[63] = ($urandom % 4) != 0;
      cyc();
    end
    reg_we = 0; ntf_valid = 0; st_ready = 1; idle(40);
    finish_run();
  end
endmodule